// File: doc/BRIEF.md
# Residual Edge Scheduler with Reliability Fallback

This block decides which message edge a dynamically scheduled belief-propagation decoder updates next. It keeps a residual for every edge and, for every variable node, a conditional-innovation score and a reliability value. Edges are grouped by node: node `v` owns edges `v*DEG` to `v*DEG+DEG-1`. On a request, the block looks at the active node with the highest score. If that node's reliability meets the threshold, the block picks that node's incoming edge with the largest residual (node mode). If not, it picks the edge with the largest residual among all edges of active nodes (global mode).

After each message computation, the surrounding decoder writes refreshed residuals through a single update port. An update takes priority over a selection requested in the same cycle. A budget counter, loaded at the start of each iteration, limits how many selections are granted. When the budget is used up, the block reports the end of the iteration. When no eligible edge has a nonzero residual, it raises an idle flag instead of making a selection.

Top module: `resid_edge_sched`

## Requirements
- R1: While `rst` is high, all residuals, scores and reliabilities are cleared, and `sel_valid`, `idle` and `iter_done` are low.
- R2: When `upd_valid` is high, `upd_res` is written to edge `upd_edge` at that clock edge, and the new value is used by any later selection.
- R3: A `sel_req` in a cycle with `upd_valid` high is dropped: `sel_valid` stays low in the next cycle and no budget is spent.
- R4: When the active node with the highest score has reliability >= `rel_thresh`, the selection is the edge `node*DEG+k` with the largest residual among that node's edges, and `sel_mode` is 1.
- R5: When that node's reliability is below `rel_thresh`, the selection is the edge with the largest residual over all edges of active nodes, and `sel_mode` is 0.
- R6: Ties in score and in residual are resolved toward the lowest index.
- R7: A node whose `vn_active` bit (bit i for node i) is 0 is never chosen as the best node, and its edges are never selected.
- R8: If the eligible candidate edge has residual 0, or no node is active, the request makes `idle` go to 1 and `sel_valid` stays 0. An evaluated request that yields a selection makes `idle` go to 0.
- R9: `iter_start` loads the budget from `budget_limit` and clears `iter_done`; a `sel_req` in the same cycle is ignored. Each granted selection reduces the budget by one. A request that arrives with a budget of 0 sets `iter_done` and grants nothing.
- R10: The results of a request appear one cycle after it. `sel_valid` is high for exactly one cycle for each granted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Residual write enable |
| upd_edge | input | EW | Edge whose residual is written |
| upd_res | input | RW | New residual value |
| node_we | input | 1 | Node score and reliability write enable |
| node_idx | input | VW | Node being written |
| node_score | input | RW | Conditional-innovation score |
| node_rel | input | RW | Reliability value |
| vn_active | input | NUM_VN | Active-node mask, bit i is node i |
| rel_thresh | input | RW | Reliability threshold |
| iter_start | input | 1 | Load the budget and start an iteration |
| budget_limit | input | BW | Number of selections allowed per iteration |
| sel_req | input | 1 | Request one selection |
| sel_valid | output | 1 | Selection granted (one-cycle pulse) |
| sel_edge | output | EW | Selected edge index |
| sel_mode | output | 1 | 1 = node mode, 0 = global mode |
| idle | output | 1 | Last evaluated request found no nonzero eligible edge |
| iter_done | output | 1 | Budget was exhausted when a request arrived |

## Verification
A single fixed set of residuals, scores and reliabilities is swept with different active masks and thresholds. Some of these combinations separate node mode from global mode on the same data. Others make tied scores and tied residuals decide the outcome, so a result that is not the lowest index shows up as a wrong edge. Masks that remove the global maximum, or leave only zero-residual nodes, separate the effect of inactive nodes from the idle case. Directed steps then check the following:
- an update that collides with a request;
- a new residual becoming the global winner;
- the budget running out and being reloaded;
- a reset in the middle of the run clearing the stored residuals.

// File: rtl/resid_sched_pkg.sv
package resid_sched_pkg;
  typedef enum logic {
    MODE_GLOBAL = 1'b0,
    MODE_NODE   = 1'b1
  } sel_mode_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/resid_sched_regs.sv
module resid_sched_regs #(
  parameter int N  = 12,
  parameter int W  = 10,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] rd_o
);
  logic [N*W-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (we && (int'(waddr) < N)) begin
      mem_q[int'(waddr)*W +: W] <= wdata;
    end
  end

  assign rd_o = mem_q;
endmodule

// File: rtl/resid_sched_argmax.sv
module resid_sched_argmax #(
  parameter int N  = 12,
  parameter int W  = 10,
  parameter int IW = 4
) (
  input  logic [N*W-1:0] vals_i,
  input  logic [N-1:0]   ok_i,
  output logic [IW-1:0]  idx_o,
  output logic [W-1:0]   val_o,
  output logic           ok_o
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;
  localparam int P  = 1 << LV;

  logic [W-1:0]  hv [1:2*P-1];
  logic [IW-1:0] hi [1:2*P-1];
  logic          hk [1:2*P-1];

  for (genvar l = 0; l < P; l++) begin : g_leaf
    if (l < N) begin : g_real
      assign hv[P+l] = vals_i[l*W +: W];
      assign hi[P+l] = IW'(l);
      assign hk[P+l] = ok_i[l];
    end else begin : g_pad
      assign hv[P+l] = '0;
      assign hi[P+l] = '0;
      assign hk[P+l] = 1'b0;
    end
  end

  for (genvar n = 1; n < P; n++) begin : g_node
    logic take_left;
    assign take_left = hk[2*n] && (!hk[2*n+1] || (hv[2*n] >= hv[2*n+1]));
    assign hv[n] = take_left ? hv[2*n] : hv[2*n+1];
    assign hi[n] = take_left ? hi[2*n] : hi[2*n+1];
    assign hk[n] = hk[2*n] || hk[2*n+1];
  end

  assign idx_o = hi[1];
  assign val_o = hv[1];
  assign ok_o  = hk[1];

  always_comb begin
    a_r7_pick_eligible : assert (!ok_o || ok_i[idx_o]);
  end
endmodule

// File: rtl/resid_edge_sched.sv
module resid_edge_sched
  import resid_sched_pkg::*;
#(
  parameter int NUM_VN = 4,
  parameter int DEG    = 3,
  parameter int RW     = 10,
  parameter int BW     = 8,
  parameter int NUM_E  = NUM_VN * DEG,
  parameter int EW     = idx_bits(NUM_E),
  parameter int VW     = idx_bits(NUM_VN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [EW-1:0]     upd_edge,
  input  logic [RW-1:0]     upd_res,
  input  logic              node_we,
  input  logic [VW-1:0]     node_idx,
  input  logic [RW-1:0]     node_score,
  input  logic [RW-1:0]     node_rel,
  input  logic [NUM_VN-1:0] vn_active,
  input  logic [RW-1:0]     rel_thresh,
  input  logic              iter_start,
  input  logic [BW-1:0]     budget_limit,
  input  logic              sel_req,
  output logic              sel_valid,
  output logic [EW-1:0]     sel_edge,
  output logic              sel_mode,
  output logic              idle,
  output logic              iter_done
);
  localparam int KW = idx_bits(DEG);
  localparam logic [EW-1:0] DEG_E = EW'(DEG);

  logic [NUM_E*RW-1:0]  res_flat;
  logic [NUM_VN*RW-1:0] score_flat;
  logic [NUM_VN*RW-1:0] rel_flat;

  resid_sched_regs #(.N(NUM_E), .W(RW), .AW(EW)) u_res (
    .clk(clk), .rst(rst), .we(upd_valid), .waddr(upd_edge),
    .wdata(upd_res), .rd_o(res_flat)
  );
  resid_sched_regs #(.N(NUM_VN), .W(RW), .AW(VW)) u_score (
    .clk(clk), .rst(rst), .we(node_we), .waddr(node_idx),
    .wdata(node_score), .rd_o(score_flat)
  );
  resid_sched_regs #(.N(NUM_VN), .W(RW), .AW(VW)) u_rel (
    .clk(clk), .rst(rst), .we(node_we), .waddr(node_idx),
    .wdata(node_rel), .rd_o(rel_flat)
  );

  // best active node by score
  logic [VW-1:0] best_vn;
  logic [RW-1:0] best_score;
  logic          best_ok;
  resid_sched_argmax #(.N(NUM_VN), .W(RW), .IW(VW)) u_node_max (
    .vals_i(score_flat), .ok_i(vn_active),
    .idx_o(best_vn), .val_o(best_score), .ok_o(best_ok)
  );

  // incoming edges of the best node
  logic [DEG*RW-1:0] node_res;
  logic [DEG-1:0]    node_ok;
  for (genvar k = 0; k < DEG; k++) begin : g_nedge
    assign node_res[k*RW +: RW] = res_flat[(int'(best_vn)*DEG + k)*RW +: RW];
    assign node_ok[k] = 1'b1;
  end

  logic [KW-1:0] k_idx;
  logic [RW-1:0] k_val;
  logic          k_ok;
  resid_sched_argmax #(.N(DEG), .W(RW), .IW(KW)) u_edge_max (
    .vals_i(node_res), .ok_i(node_ok),
    .idx_o(k_idx), .val_o(k_val), .ok_o(k_ok)
  );

  // global search over edges of active nodes
  logic [NUM_E-1:0] g_elig;
  for (genvar e = 0; e < NUM_E; e++) begin : g_gmask
    assign g_elig[e] = vn_active[e / DEG];
  end

  logic [EW-1:0] g_idx;
  logic [RW-1:0] g_val;
  logic          g_ok;
  resid_sched_argmax #(.N(NUM_E), .W(RW), .IW(EW)) u_glob_max (
    .vals_i(res_flat), .ok_i(g_elig),
    .idx_o(g_idx), .val_o(g_val), .ok_o(g_ok)
  );

  logic          node_mode;
  logic          cand_ok;
  logic [EW-1:0] cand_edge;
  logic [RW-1:0] best_rel;

  assign best_rel  = rel_flat[int'(best_vn)*RW +: RW];
  assign node_mode = best_ok && (best_rel >= rel_thresh);
  assign cand_edge = node_mode ? (EW'(best_vn) * DEG_E + EW'(k_idx)) : g_idx;
  assign cand_ok   = node_mode ? (k_ok && (k_val != '0)) : (g_ok && (g_val != '0));

  logic [BW-1:0] budget_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_edge  <= '0;
      sel_mode  <= MODE_GLOBAL;
      idle      <= 1'b0;
      iter_done <= 1'b0;
      budget_q  <= '0;
    end else begin
      sel_valid <= 1'b0;
      if (iter_start) begin
        budget_q  <= budget_limit;
        iter_done <= 1'b0;
      end else if (sel_req && !upd_valid) begin
        if (budget_q == '0) begin
          iter_done <= 1'b1;
          idle      <= 1'b0;
        end else if (!cand_ok) begin
          idle <= 1'b1;
        end else begin
          idle      <= 1'b0;
          sel_valid <= 1'b1;
          sel_edge  <= cand_edge;
          sel_mode  <= node_mode ? MODE_NODE : MODE_GLOBAL;
          budget_q  <= budget_q - 1'b1;
        end
      end
    end
  end

  a_r3_update_first : assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !sel_valid);
  a_r9_done_blocks_sel : assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> !iter_done);
  a_r7_active_edge : assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ((($past(vn_active) >> (sel_edge / DEG_E)) & NUM_VN'(1)) != '0));
  a_r8_nonzero_pick : assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (res_flat[int'(sel_edge)*RW +: RW] != '0));
  a_r8_idle_excl : assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> !idle);
endmodule

// File: tb/resid_edge_sched_tb_top.sv
module resid_edge_sched_tb_top;
  localparam int NUM_VN = 4;
  localparam int DEG    = 3;
  localparam int RW     = 10;
  localparam int BW     = 8;
  localparam int EW     = 4;
  localparam int VW     = 2;
  localparam int NV     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0;
  logic [EW-1:0] upd_edge = '0;
  logic [RW-1:0] upd_res = '0;
  logic node_we = 1'b0;
  logic [VW-1:0] node_idx = '0;
  logic [RW-1:0] node_score = '0;
  logic [RW-1:0] node_rel = '0;
  logic [NUM_VN-1:0] vn_active = '0;
  logic [RW-1:0] rel_thresh = '0;
  logic iter_start = 1'b0;
  logic [BW-1:0] budget_limit = '0;
  logic sel_req = 1'b0;
  logic sel_valid, sel_mode, idle, iter_done;
  logic [EW-1:0] sel_edge;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  resid_edge_sched #(.NUM_VN(NUM_VN), .DEG(DEG), .RW(RW), .BW(BW)) dut_i (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_edge(upd_edge),
    .upd_res(upd_res), .node_we(node_we), .node_idx(node_idx),
    .node_score(node_score), .node_rel(node_rel), .vn_active(vn_active),
    .rel_thresh(rel_thresh), .iter_start(iter_start),
    .budget_limit(budget_limit), .sel_req(sel_req), .sel_valid(sel_valid),
    .sel_edge(sel_edge), .sel_mode(sel_mode), .idle(idle),
    .iter_done(iter_done)
  );

  // mask, threshold, expected valid, edge, mode, idle
  localparam logic [3:0] V_MASK [NV] = '{4'b1111, 4'b1111, 4'b0111, 4'b1101,
                                          4'b1001, 4'b1000, 4'b0000, 4'b0100};
  localparam int V_THR  [NV] = '{40, 60, 60, 60, 60, 60, 60, 400};
  localparam int V_OK   [NV] = '{1, 1, 1, 0, 1, 1, 0, 0};
  localparam int V_EDGE [NV] = '{3, 9, 3, 0, 1, 9, 0, 0};
  localparam int V_MODE [NV] = '{1, 0, 0, 0, 1, 0, 0, 0};
  localparam string V_REQ [NV] = '{"R4 R6", "R5", "R7 R6", "R8", "R4 R6",
                                    "R5 R7", "R8 R7", "R8"};
  localparam int RES_INIT [12] = '{4, 8, 8, 20, 3, 20, 0, 0, 0, 30, 1, 2};
  localparam int SCORE_INIT [4] = '{5, 9, 9, 2};
  localparam int REL_INIT [4] = '{100, 50, 300, 7};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_res(input int e, input int v);
    upd_valid = 1'b1; upd_edge = EW'(e); upd_res = RW'(v);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic write_node(input int i, input int s, input int r);
    node_we = 1'b1; node_idx = VW'(i); node_score = RW'(s); node_rel = RW'(r);
    @(negedge clk);
    node_we = 1'b0;
  endtask

  task automatic start_iter(input int b);
    iter_start = 1'b1; budget_limit = BW'(b);
    @(negedge clk);
    iter_start = 1'b0;
  endtask

  task automatic request(input logic [3:0] m, input int thr);
    vn_active = m; rel_thresh = RW'(thr); sel_req = 1'b1;
    @(negedge clk);
    sel_req = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: outputs low during reset
    check("R1 sel_valid", int'(sel_valid), 0);
    check("R1 idle", int'(idle), 0);
    check("R1 iter_done", int'(iter_done), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int e = 0; e < 12; e++) write_res(e, RES_INIT[e]);
    for (int i = 0; i < 4; i++) write_node(i, SCORE_INIT[i], REL_INIT[i]);
    start_iter(20);

    for (int v = 0; v < NV; v++) begin
      request(V_MASK[v], V_THR[v]);
      check({V_REQ[v], " valid"}, int'(sel_valid), V_OK[v]);
      check({V_REQ[v], " idle"}, int'(idle), 1 - V_OK[v]);
      if (V_OK[v] == 1) begin
        check({V_REQ[v], " edge"}, int'(sel_edge), V_EDGE[v]);
        check({V_REQ[v], " mode"}, int'(sel_mode), V_MODE[v]);
      end
    end

    // R10: pulse lasts one cycle
    request(4'b1111, 40);
    check("R10 granted", int'(sel_valid), 1);
    @(negedge clk);
    check("R10 pulse low", int'(sel_valid), 0);

    // R3: update collides with request
    vn_active = 4'b1111; rel_thresh = RW'(60); sel_req = 1'b1;
    upd_valid = 1'b1; upd_edge = EW'(7); upd_res = RW'(50);
    @(negedge clk);
    sel_req = 1'b0; upd_valid = 1'b0;
    check("R3 dropped", int'(sel_valid), 0);

    // R2: new residual wins globally, R8 idle cleared
    request(4'b1111, 60);
    check("R2 valid", int'(sel_valid), 1);
    check("R2 edge", int'(sel_edge), 7);
    check("R8 idle cleared", int'(idle), 0);

    // R9: budget
    start_iter(2);
    check("R9 done cleared", int'(iter_done), 0);
    request(4'b1111, 60);
    check("R9 first", int'(sel_valid), 1);
    request(4'b1111, 60);
    check("R9 second", int'(sel_valid), 1);
    request(4'b1111, 60);
    check("R9 exhausted valid", int'(sel_valid), 0);
    check("R9 exhausted done", int'(iter_done), 1);
    start_iter(5);
    check("R9 reload clears", int'(iter_done), 0);
    request(4'b1111, 60);
    check("R9 after reload", int'(sel_valid), 1);

    // R1: reset clears stored residuals
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    start_iter(5);
    request(4'b1111, 0);
    check("R1 cleared idle", int'(idle), 1);
    check("R1 cleared valid", int'(sel_valid), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule